// File: doc/BRIEF.md
# Attention-Selection Bus Phase Tracker

This block follows the bus phases a parallel SCSI target goes through when it is selected with attention asserted while packetized information-unit transfers have been agreed. It does not look at the bus wires. Instead it takes already-decoded observations: bus free seen, arbitration won, selection complete, attention asserted, message-out finished and message-in finished. From these it keeps a single current phase. It accepts only one fixed walk through the phases: free, arbitration, selection, message out, message in, and back to free. Any observation that does not fit the current phase counts as a protocol violation, and the tracker then falls back to the free phase.

A hard-reset input and a quick-arbitration strap sit alongside the observations. Quick arbitration is not supported, so while the strap is set the tracker flags the mode as unsupported and holds the free phase. All outputs are registered. The phase code, the advance pulse and the error pulse all reflect the inputs sampled on the previous rising clock edge.

Top module: `phase_seq_tracker`

## Requirements
- R1: A synchronous active-high `rst` makes `phase_o` equal 0 and drives every flag output low on the following cycle.
- R2: Phases are coded FREE=0, ARB=1, SEL=2, MSGOUT=3, MSGIN=4. The only advancing walk is 0 to 1 on `arb_won_i`, 1 to 2 on `sel_done_i`, 2 to 3 on `atn_i`, 3 to 4 on `mout_done_i`, and 4 to 0 on `min_done_i`. The new phase is visible one cycle after the event is sampled.
- R3: `adv_pulse_o` is high for exactly one cycle, the one that follows each legal advance, and is low otherwise.
- R4: Any observation other than the expected one for the current phase raises `proto_err_o` for one cycle and sets `phase_o` to 0. This holds even when the expected event arrives in the same cycle. While `proto_err_o` is high, `adv_pulse_o` is low.
- R5: `bus_free_i` while in phase 0 is ignored. The phase stays 0 and no error is raised.
- R6: `hard_rst_i` sets `phase_o` to 0 on the next cycle with both pulses low, whatever observations arrive with it.
- R7: While `qas_en_i` is high (and `hard_rst_i` is low), the next cycle shows phase 0, no advance and no error. `unsupported_o` equals `qas_en_i` as sampled on the previous edge.
- R8: With no observations, no hard reset and no strap, the phase holds and both pulses stay low.
- R9: Phase 2 can be entered only from phase 1. `sel_done_i` in any other phase is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hard_rst_i | input | 1 | Bus hard reset observed |
| qas_en_i | input | 1 | Quick-arbitration enable strap |
| bus_free_i | input | 1 | Bus free observed |
| arb_won_i | input | 1 | Arbitration won |
| sel_done_i | input | 1 | Selection completed |
| atn_i | input | 1 | Attention asserted after selection |
| mout_done_i | input | 1 | Message-out phase finished |
| min_done_i | input | 1 | Message-in phase finished |
| phase_o | output | 3 | Current phase code |
| adv_pulse_o | output | 1 | One-cycle pulse after a legal advance |
| proto_err_o | output | 1 | One-cycle pulse after a protocol violation |
| unsupported_o | output | 1 | Quick-arbitration mode flagged as unsupported |

## Verification
The checker holds several rules on every cycle:
- the phase code stays in range;
- an advance always moves to the successor of the previous phase;
- an error always lands in phase 0;
- advance and error never coincide;
- hard reset and the strap override everything;
- quiet cycles change nothing.

Some properties only the bench scenarios can show. These are the full walk through all five phases, the exact mapping of each observation to the phase that expects it, and the priority when a legal and an illegal observation arrive together. The same holds for the tolerance of bus free while idle and for long random runs that return through the error and reset paths.

// File: rtl/pst_pkg.sv
package pst_pkg;

   localparam int PH_W = 3;
   localparam int PH_N = 5;
   localparam int EV_N = PH_N + 1;

   // observation bit positions; bit k+1 is the event phase k waits for
   localparam int EV_FREE = 0;
   localparam int EV_ARB  = 1;
   localparam int EV_SEL  = 2;
   localparam int EV_ATN  = 3;
   localparam int EV_MOUT = 4;
   localparam int EV_MIN  = 5;

   typedef enum logic [PH_W-1:0] {
      PH_FREE = 3'd0,
      PH_ARB  = 3'd1,
      PH_SEL  = 3'd2,
      PH_MOUT = 3'd3,
      PH_MIN  = 3'd4
   } phase_t;

   function automatic phase_t succ(input phase_t p);
      case (p)
         PH_FREE: succ = PH_ARB;
         PH_ARB:  succ = PH_SEL;
         PH_SEL:  succ = PH_MOUT;
         PH_MOUT: succ = PH_MIN;
         default: succ = PH_FREE;
      endcase
   endfunction

endpackage

// File: rtl/pst_req_decode.sv
module pst_req_decode #(
   parameter int PH_W = pst_pkg::PH_W,
   parameter int EV_N = pst_pkg::EV_N
) (
   input  logic [PH_W-1:0] phase_i,
   input  logic [EV_N-1:0] ev_i,
   output logic            adv_o,
   output logic            bad_o
);
   logic [EV_N-1:0] want;
   logic [EV_N-1:0] tol;

   generate
      for (genvar i = 0; i < EV_N; i++) begin : g_mask
         if (i == pst_pkg::EV_FREE) begin : g_free
            assign want[i] = 1'b0;
            assign tol[i]  = (phase_i == PH_W'(pst_pkg::PH_FREE));
         end else begin : g_step
            assign want[i] = (phase_i == PH_W'(i - 1));
            assign tol[i]  = 1'b0;
         end
      end
   endgenerate

   assign adv_o = |(ev_i & want);
   assign bad_o = |(ev_i & ~(want | tol));

endmodule

// File: rtl/pst_phase_ctl.sv
module pst_phase_ctl #(
   parameter int PH_W = pst_pkg::PH_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hard_i,
   input  logic            qas_i,
   input  logic            adv_i,
   input  logic            bad_i,
   output logic [PH_W-1:0] phase_o,
   output logic            adv_o,
   output logic            err_o,
   output logic            uns_o
);
   import pst_pkg::*;

   phase_t ph_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= PH_FREE;
         adv_o <= 1'b0;
         err_o <= 1'b0;
         uns_o <= 1'b0;
      end else begin
         uns_o <= qas_i;
         adv_o <= 1'b0;
         err_o <= 1'b0;
         if (hard_i) begin
            ph_q <= PH_FREE;
         end else if (qas_i) begin
            ph_q <= PH_FREE;
         end else if (bad_i) begin
            ph_q  <= PH_FREE;
            err_o <= 1'b1;
         end else if (adv_i) begin
            ph_q  <= succ(ph_q);
            adv_o <= 1'b1;
         end
      end
   end

   assign phase_o = ph_q;

endmodule

// File: rtl/phase_seq_tracker.sv
module phase_seq_tracker #(
   parameter int PH_W = pst_pkg::PH_W,
   parameter int EV_N = pst_pkg::EV_N
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hard_rst_i,
   input  logic            qas_en_i,
   input  logic            bus_free_i,
   input  logic            arb_won_i,
   input  logic            sel_done_i,
   input  logic            atn_i,
   input  logic            mout_done_i,
   input  logic            min_done_i,
   output logic [PH_W-1:0] phase_o,
   output logic            adv_pulse_o,
   output logic            proto_err_o,
   output logic            unsupported_o
);
   generate
      if (PH_W != pst_pkg::PH_W) begin : g_bad_w
         $error("PH_W must match the phase type width");
      end
      if (EV_N != pst_pkg::PH_N + 1) begin : g_bad_n
         $error("EV_N must be one more than the phase count");
      end
   endgenerate

   logic [EV_N-1:0] ev;
   logic            adv_req;
   logic            bad_req;

   assign ev = {min_done_i, mout_done_i, atn_i, sel_done_i, arb_won_i, bus_free_i};

   pst_req_decode #(.PH_W(PH_W), .EV_N(EV_N)) u_dec (
      .phase_i (phase_o),
      .ev_i    (ev),
      .adv_o   (adv_req),
      .bad_o   (bad_req)
   );

   pst_phase_ctl #(.PH_W(PH_W)) u_ctl (
      .clk     (clk),
      .rst     (rst),
      .hard_i  (hard_rst_i),
      .qas_i   (qas_en_i),
      .adv_i   (adv_req),
      .bad_i   (bad_req),
      .phase_o (phase_o),
      .adv_o   (adv_pulse_o),
      .err_o   (proto_err_o),
      .uns_o   (unsupported_o)
   );

endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
   parameter int PH_W = 3
) (
   input logic            clk,
   input logic            rst,
   input logic            hard_rst_i,
   input logic            qas_en_i,
   input logic            any_ev,
   input logic            sel_done_i,
   input logic [PH_W-1:0] phase_o,
   input logic            adv_pulse_o,
   input logic            proto_err_o,
   input logic            unsupported_o
);
   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (phase_o == '0 && !adv_pulse_o && !proto_err_o && !unsupported_o));

   a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
      phase_o <= PH_W'(4));

   a_r3_adv_successor: assert property (@(posedge clk) disable iff (rst)
      adv_pulse_o |-> (phase_o == (($past(phase_o) == PH_W'(4)) ? '0 : $past(phase_o) + PH_W'(1))));

   a_r4_err_free: assert property (@(posedge clk) disable iff (rst)
      proto_err_o |-> (phase_o == '0 && !adv_pulse_o));

   a_r6_hard_wins: assert property (@(posedge clk) disable iff (rst)
      hard_rst_i |=> (phase_o == '0 && !adv_pulse_o && !proto_err_o));

   a_r7_qas_hold: assert property (@(posedge clk) disable iff (rst)
      (qas_en_i && !hard_rst_i) |=> (phase_o == '0 && unsupported_o && !adv_pulse_o && !proto_err_o));

   a_r8_quiet_hold: assert property (@(posedge clk) disable iff (rst)
      (!hard_rst_i && !qas_en_i && !any_ev) |=> ($stable(phase_o) && !adv_pulse_o && !proto_err_o));

   a_r9_sel_from_arb: assert property (@(posedge clk) disable iff (rst)
      (adv_pulse_o && phase_o == PH_W'(2)) |-> ($past(phase_o) == PH_W'(1) && $past(sel_done_i)));

   a_r4_pulse_excl: assert property (@(posedge clk) disable iff (rst)
      $onehot0({adv_pulse_o, proto_err_o}));
endmodule

bind phase_seq_tracker pst_checker #(.PH_W(PH_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .hard_rst_i    (hard_rst_i),
   .qas_en_i      (qas_en_i),
   .any_ev        (|{bus_free_i, arb_won_i, sel_done_i, atn_i, mout_done_i, min_done_i}),
   .sel_done_i    (sel_done_i),
   .phase_o       (phase_o),
   .adv_pulse_o   (adv_pulse_o),
   .proto_err_o   (proto_err_o),
   .unsupported_o (unsupported_o)
);

// File: tb/tb_phase_seq_tracker.sv
module tb_phase_seq_tracker;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       hard = 1'b0;
   logic       qas = 1'b0;
   logic [5:0] ev = '0;
   logic [2:0] phase;
   logic       adv, err, uns;

   int total = 0;
   int bad = 0;

   logic [2:0] m_ph = '0;
   logic       m_adv = 1'b0, m_err = 1'b0, m_uns = 1'b0;
   string      m_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_seq_tracker dut (
      .clk(clk), .rst(rst), .hard_rst_i(hard), .qas_en_i(qas),
      .bus_free_i(ev[0]), .arb_won_i(ev[1]), .sel_done_i(ev[2]),
      .atn_i(ev[3]), .mout_done_i(ev[4]), .min_done_i(ev[5]),
      .phase_o(phase), .adv_pulse_o(adv), .proto_err_o(err), .unsupported_o(uns)
   );

   // phase p expects observation bit p+1; bus free tolerated only in phase 0
   task automatic model(input logic r, input logic h, input logic q, input logic [5:0] e);
      logic [5:0] want, tol;
      want = (m_ph <= 3'd4) ? (6'b000010 << m_ph) : 6'b0;
      tol  = (m_ph == 3'd0) ? 6'b000001 : 6'b0;
      m_adv = 1'b0; m_err = 1'b0;
      if (r) begin
         m_ph = 0; m_uns = 0; m_tag = "R1";
      end else begin
         m_uns = q;
         if (h) begin m_ph = 0; m_tag = "R6"; end
         else if (q) begin m_ph = 0; m_tag = "R7"; end
         else if ((e & ~(want | tol)) != 0) begin
            m_ph = 0; m_err = 1; m_tag = e[2] ? "R9" : "R4";
         end else if ((e & want) != 0) begin
            m_ph = (m_ph == 3'd4) ? 3'd0 : m_ph + 3'd1; m_adv = 1;
            m_tag = "R2/R3";
         end else m_tag = (e[0]) ? "R5" : "R8";
      end
   endtask

   task automatic check(input string tag);
      total++;
      if ({phase, adv, err, uns} !== {m_ph, m_adv, m_err, m_uns}) begin
         bad++;
         $display("FAIL %s: got ph=%0d adv=%0b err=%0b uns=%0b exp ph=%0d adv=%0b err=%0b uns=%0b",
                  tag, phase, adv, err, uns, m_ph, m_adv, m_err, m_uns);
      end
   endtask

   // called at a negedge: drive, model, wait one cycle, check at next negedge
   task automatic step(input logic r, input logic h, input logic q, input logic [5:0] e);
      rst = r; hard = h; qas = q; ev = e;
      model(r, h, q, e);
      @(negedge clk);
      check(m_tag);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1");
      // R2/R3 full walk
      step(0,0,0,6'b000010);
      step(0,0,0,6'b000100);
      step(0,0,0,6'b001000);
      step(0,0,0,6'b010000);
      step(0,0,0,6'b100000);
      // R5 bus free in idle ignored, R8 quiet hold
      step(0,0,0,6'b000001);
      step(0,0,0,6'b000000);
      // R9 selection done while idle
      step(0,0,0,6'b000100);
      // R4 legal plus illegal together in ARB
      step(0,0,0,6'b000010);
      step(0,0,0,6'b000110 | 6'b010000);
      // R4 bus free during selection
      step(0,0,0,6'b000010);
      step(0,0,0,6'b000100);
      step(0,0,0,6'b000001);
      // R6 hard reset overrides legal event
      step(0,0,0,6'b000010);
      step(0,1,0,6'b000100);
      // R7 strap holds free, then released
      step(0,0,1,6'b000010);
      step(0,0,1,6'b000000);
      step(0,0,0,6'b000000);
      // R1 mid-walk reset
      step(0,0,0,6'b000010);
      step(1,0,0,6'b000100);
      step(0,0,0,6'b000000);
      // constrained random
      void'($urandom(32'd20240607));
      for (int i = 0; i < 3000; i++) begin
         logic [5:0] e;
         int sel;
         sel = $urandom_range(99);
         if (sel < 70) e = (m_ph <= 3'd4) ? (6'b000010 << m_ph) : 6'b0;
         else if (sel < 85) e = 6'b0;
         else e = 6'($urandom_range(63));
         step(($urandom_range(199) == 0), ($urandom_range(49) == 0),
              ($urandom_range(39) == 0), e);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule